// File: doc/BRIEF.md
# Serial GPIO Shift Slice

This block is one serial input/output lane that turns a bit stream into 32-bit words, or 32-bit words into a bit stream. A one-cycle strobe marks each shift event. On that event the slice moves exactly one bit: it captures a bit from its pin or from a neighbouring slice, or it drives the next bit of a word to its pin. A 32-bit working register does the shifting. A 32-bit shadow buffer holds the other word, so software can fetch a finished word, or stage the next one, while shifting goes on.

A programmable position counter counts the shift events. When it expires, the working register and the shadow buffer exchange contents. A masked comparator checks the working register against a programmed pattern. Three sticky status causes (word swap, shift event and pattern match) each have their own enable, and the enabled causes are ORed into one interrupt line. A chain input and a chain output let several slices form one longer shift path. A divider counts rising edges of the slice's output bit and brings out a signal at 1/128 of that edge rate.

The slice runs entirely on its own clock and has a synchronous active-high reset.

Top module: `serial_io_slice`

## Requirements
- R1: While `rst` is high at a clock edge, the working register, the shadow buffer, the status bits and the edge divider clear to zero, and the position counter loads `pos_reload`.
- R2: On a cycle with `shift_en` high and no swap, the working register shifts right by one and the entering bit lands in bit 31. On a cycle with `shift_en` low, the working register does not change.
- R3: `pin_out` always equals bit 0 of the working register, so data leaves LSB first. `pin_oe` equals `dir_out`. With `dir_out`=1 and no chaining, the entering bit is 0.
- R4: The position counter decrements on each shift event. A shift event that finds it at 0 is a swap. On a swap the shifted word goes to the shadow buffer, the old shadow word goes to the working register, and the counter reloads. A swap therefore happens once every `pos_reload`+1 shift events.
- R5: `shadow_wr` loads `shadow_wdata` into the shadow buffer in any cycle without a swap. In a swap cycle the swap wins and the write is dropped.
- R6: `status` holds three sticky bits: bit 0 for swap, bit 1 for shift event, bit 2 for pattern match. A 1 in `status_clr` clears the matching bit. If a bit is set and cleared in the same cycle, the set wins.
- R7: `irq` is high exactly when some bit of `status` is set and its bit in `irq_en` is also set.
- R8: A match exists in a cycle when the working register equals `pattern` in every bit where `mask` is 0 (a mask bit of 1 means don't care). A match sets status bit 2 at the next edge.
- R9: With `use_cascade`=1, the entering bit is `cascade_in` in both directions. `cascade_out` always equals bit 0 of the working register.
- R10: A 7-bit counter counts the cycles in which `pin_out` is 1 after being 0 in the previous cycle. `div128_out` is its top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Shift event strobe |
| dir_out | input | 1 | 1 = parallel-to-serial (drive pin), 0 = capture |
| use_cascade | input | 1 | Take the entering bit from the neighbour slice |
| pin_in | input | 1 | Serial input from the pin |
| cascade_in | input | 1 | Serial input from the previous slice |
| pos_reload | input | 8 | Shift events per swap, minus one |
| pattern | input | 32 | Compare pattern |
| mask | input | 32 | Don't-care bits for the compare (1 = ignore) |
| shadow_wr | input | 1 | Load strobe for the shadow buffer |
| shadow_wdata | input | 32 | Word to load into the shadow buffer |
| irq_en | input | 3 | Interrupt enable per cause |
| status_clr | input | 3 | Clear strobe per cause |
| shift_rdata | output | 32 | Working register contents |
| shadow_rdata | output | 32 | Shadow buffer contents |
| pin_out | output | 1 | Serial output to the pin |
| pin_oe | output | 1 | Pin output enable |
| cascade_out | output | 1 | Serial output to the next slice |
| div128_out | output | 1 | Output-edge divider tap |
| status | output | 3 | Sticky causes {match, shift, swap} |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check four things: the hold and right-shift of the working register, the exchange at a swap, the stability of the shadow buffer when neither a swap nor a write occurs, and the sticky set/clear rule of the status bits. They also check that the divider advances only on a rising output edge. Other behaviours need the bench's scenarios, which run against an arithmetic model across reload values, directions and chaining. These behaviours are: the correct swap spacing for each reload value, the dropped write in a swap cycle, the masked match decision, the LSB-first order of a full captured and driven word, and the 1/128 divider output.

// File: rtl/slice_pkg.sv
`timescale 1ns/1ps
package slice_pkg;
  localparam int unsigned NUM_CAUSE = 3;
  localparam int unsigned CAUSE_SWAP  = 0;
  localparam int unsigned CAUSE_SHIFT = 1;
  localparam int unsigned CAUSE_MATCH = 2;
  typedef logic [NUM_CAUSE-1:0] cause_t;

  // Entering bit: chain input wins, else the pin in capture mode, else 0.
  function automatic logic pick_enter(input logic chain, input logic out_mode,
                                      input logic pin, input logic chain_bit);
    if (chain) return chain_bit;
    if (out_mode) return 1'b0;
    return pin;
  endfunction
endpackage

// File: rtl/slice_shifter.sv
`timescale 1ns/1ps
module slice_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned POS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              enter_bit,
  input  logic [POS_W-1:0]  pos_reload,
  input  logic              shadow_wr,
  input  logic [DATA_W-1:0] shadow_wdata,
  output logic [DATA_W-1:0] work_q,
  output logic [DATA_W-1:0] shadow_q,
  output logic              swap_evt
);
  logic [POS_W-1:0]  pos_q;
  logic [DATA_W-1:0] shifted;

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] w,
                                                 input logic b);
    return {b, w[DATA_W-1:1]};
  endfunction

  assign shifted  = shift_in(work_q, enter_bit);
  assign swap_evt = shift_en && (pos_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      pos_q  <= pos_reload;
    end else if (shift_en) begin
      if (swap_evt) begin
        work_q <= shadow_q;
        pos_q  <= pos_reload;
      end else begin
        work_q <= shifted;
        pos_q  <= pos_q - POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) shadow_q <= '0;
    else if (swap_evt) shadow_q <= shifted;
    else if (shadow_wr) shadow_q <= shadow_wdata;
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(work_q));
  // R2
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !swap_evt) |=> work_q[DATA_W-2:0] == $past(work_q[DATA_W-1:1]));
  // R4
  swap_chk: assert property (@(posedge clk) disable iff (rst)
    swap_evt |=> work_q == $past(shadow_q));
  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!swap_evt && !shadow_wr) |=> $stable(shadow_q));
endmodule

// File: rtl/slice_match.sv
`timescale 1ns/1ps
module slice_match #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] pattern,
  input  logic [DATA_W-1:0] mask,
  output logic              match_evt
);
  function automatic logic masked_equal(input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b,
                                        input logic [DATA_W-1:0] dc);
    return ((a ^ b) & ~dc) == '0;
  endfunction

  assign match_evt = masked_equal(word, pattern, mask);
endmodule

// File: rtl/slice_status.sv
`timescale 1ns/1ps
module slice_status
  import slice_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  cause_t set_vec,
  input  cause_t clr_vec,
  input  cause_t en_vec,
  output cause_t status_q,
  output logic   irq
);
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else status_q <= (status_q & ~clr_vec) | set_vec;
  end

  assign irq = |(status_q & en_vec);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_q & $past(status_q & ~clr_vec)) == $past(status_q & ~clr_vec));
  // R6
  set_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> (status_q & $past(set_vec)) == $past(set_vec));
endmodule

// File: rtl/slice_divider.sv
`timescale 1ns/1ps
module slice_divider #(
  parameter int unsigned DIV_W = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic edge_evt,
  output logic div_out
);
  logic             prev_q;
  logic [DIV_W-1:0] cnt_q;

  assign edge_evt = sig && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= sig;
      cnt_q  <= cnt_q + DIV_W'(edge_evt);
    end
  end

  assign div_out = cnt_q[DIV_W-1];

  // R10
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_evt |=> $stable(cnt_q));
endmodule

// File: rtl/serial_io_slice.sv
`timescale 1ns/1ps
module serial_io_slice
  import slice_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned POS_W  = 8,
  parameter int unsigned DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              dir_out,
  input  logic              use_cascade,
  input  logic              pin_in,
  input  logic              cascade_in,
  input  logic [POS_W-1:0]  pos_reload,
  input  logic [DATA_W-1:0] pattern,
  input  logic [DATA_W-1:0] mask,
  input  logic              shadow_wr,
  input  logic [DATA_W-1:0] shadow_wdata,
  input  logic [NUM_CAUSE-1:0] irq_en,
  input  logic [NUM_CAUSE-1:0] status_clr,
  output logic [DATA_W-1:0] shift_rdata,
  output logic [DATA_W-1:0] shadow_rdata,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              cascade_out,
  output logic              div128_out,
  output logic [NUM_CAUSE-1:0] status,
  output logic              irq
);
  logic   enter_bit;
  logic   swap_evt;
  logic   match_evt;
  logic   edge_evt;
  cause_t set_vec;

  assign enter_bit = pick_enter(use_cascade, dir_out, pin_in, cascade_in);

  slice_shifter #(.DATA_W(DATA_W), .POS_W(POS_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .enter_bit(enter_bit),
    .pos_reload(pos_reload), .shadow_wr(shadow_wr), .shadow_wdata(shadow_wdata),
    .work_q(shift_rdata), .shadow_q(shadow_rdata), .swap_evt(swap_evt)
  );

  slice_match #(.DATA_W(DATA_W)) u_match (
    .word(shift_rdata), .pattern(pattern), .mask(mask), .match_evt(match_evt)
  );

  always_comb begin
    set_vec = '0;
    set_vec[CAUSE_SWAP]  = swap_evt;
    set_vec[CAUSE_SHIFT] = shift_en;
    set_vec[CAUSE_MATCH] = match_evt;
  end

  slice_status u_status (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(status_clr),
    .en_vec(irq_en), .status_q(status), .irq(irq)
  );

  assign pin_out     = shift_rdata[0];
  assign cascade_out = shift_rdata[0];
  assign pin_oe      = dir_out;

  slice_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .sig(pin_out), .edge_evt(edge_evt), .div_out(div128_out)
  );

  // R8
  match_set_chk: assert property (@(posedge clk) disable iff (rst)
    match_evt |=> status[CAUSE_MATCH]);
  // R4
  swap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    swap_evt |=> status[CAUSE_SWAP]);
endmodule

// File: tb/serial_io_slice_test.sv
`timescale 1ns/1ps
module serial_io_slice_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        shift_en = 0, dir_out = 0, use_cascade = 0, pin_in = 0, cascade_in = 0;
  logic [7:0]  pos_reload = 8'd31;
  logic [31:0] pattern = 0, mask = 32'hFFFF_FFFF;
  logic        shadow_wr = 0;
  logic [31:0] shadow_wdata = 0;
  logic [2:0]  irq_en = 0, status_clr = 0;
  logic [31:0] shift_rdata, shadow_rdata;
  logic        pin_out, pin_oe, cascade_out, div128_out, irq;
  logic [2:0]  status;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_sr, m_sh;
  int          m_pos;
  logic [2:0]  m_st;
  int          m_edges;
  logic        m_prev;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  serial_io_slice uut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .dir_out(dir_out),
    .use_cascade(use_cascade), .pin_in(pin_in), .cascade_in(cascade_in),
    .pos_reload(pos_reload), .pattern(pattern), .mask(mask),
    .shadow_wr(shadow_wr), .shadow_wdata(shadow_wdata), .irq_en(irq_en),
    .status_clr(status_clr), .shift_rdata(shift_rdata), .shadow_rdata(shadow_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .cascade_out(cascade_out),
    .div128_out(div128_out), .status(status), .irq(irq)
  );

  function automatic logic [31:0] rnd(inout logic [31:0] s);
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    return s;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // advance the reference by one edge, using the inputs present at that edge
  task automatic model_step();
    logic inb, swp, mt, rise;
    logic [31:0] nxt, old_sh;
    if (rst) begin
      m_sr = 0; m_sh = 0; m_pos = pos_reload; m_st = 0; m_edges = 0; m_prev = 0;
      return;
    end
    inb = use_cascade ? cascade_in : (dir_out ? 1'b0 : pin_in);
    nxt = (m_sr >> 1) | ({31'd0, inb} << 31);
    swp = shift_en && (m_pos == 0);
    mt  = ((m_sr ^ pattern) & ~mask) == 32'd0;
    rise = m_sr[0] && !m_prev;
    m_st = (m_st & ~status_clr) | {mt, shift_en, swp};
    if (rise) m_edges = m_edges + 1;
    m_prev = m_sr[0];
    old_sh = m_sh;
    if (shift_en) begin
      if (swp) begin m_sr = old_sh; m_sh = nxt; m_pos = pos_reload; end
      else begin m_sr = nxt; m_pos = m_pos - 1; end
    end
    if (shadow_wr && !swp) m_sh = shadow_wdata;
  endtask

  task automatic compare_all();
    check("R2", "shift_rdata", shift_rdata, m_sr);
    check("R4", "shadow_rdata", {31'd0, 1'b0} | shadow_rdata, m_sh);
    check("R3", "pin_out", {31'd0, pin_out}, {31'd0, m_sr[0]});
    check("R3", "pin_oe", {31'd0, pin_oe}, {31'd0, dir_out});
    check("R9", "cascade_out", {31'd0, cascade_out}, {31'd0, m_sr[0]});
    check("R6", "status", {29'd0, status}, {29'd0, m_st});
    check("R7", "irq", {31'd0, irq}, {31'd0, |(m_st & irq_en)});
    check("R10", "div128_out", {31'd0, div128_out}, {31'd0, m_edges[6]});
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1; shift_en = 0; shadow_wr = 0; status_clr = 0;
    tick();
    check("R1", "reset shift", shift_rdata, 32'd0);
    check("R1", "reset shadow", shadow_rdata, 32'd0);
    check("R1", "reset status", {29'd0, status}, 32'd0);
    check("R1", "reset div", {31'd0, div128_out}, 32'd0);
    rst = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] word_a, word_b, r;
    logic [7:0]  reloads [4];
    reloads[0] = 8'd0; reloads[1] = 8'd1; reloads[2] = 8'd3; reloads[3] = 8'd31;
    word_a = 32'hA5C3_0F96;
    word_b = 32'h3C69_E17B;
    #1;

    // Directed: capture a whole word LSB first (R2, R4)
    pos_reload = 8'd31; dir_out = 0; use_cascade = 0;
    do_reset();
    for (int i = 0; i < 32; i++) begin
      shift_en = 1; pin_in = word_a[i];
      tick();
    end
    shift_en = 0;
    check("R4", "captured word in shadow", shadow_rdata, word_a);
    check("R4", "swap flag", {31'd0, status[0]}, 32'd1);

    // Directed: drive a word out LSB first (R3, R5)
    dir_out = 1; shadow_wr = 1; shadow_wdata = word_b;
    tick();
    shadow_wr = 0;
    check("R5", "shadow load", shadow_rdata, word_b);
    for (int i = 0; i < 32; i++) begin
      shift_en = 1; tick();
    end
    shift_en = 0;
    check("R4", "driven word loaded", shift_rdata, word_b);

    // Directed: masked match while idle, set beats clear (R8, R6)
    pattern = word_b ^ 32'h0000_0100; mask = 32'h0000_0100; status_clr = 3'b111;
    tick();
    status_clr = 0;
    check("R8", "match under mask", {29'd0, status}, 32'd4);
    pattern = word_b ^ 32'h0000_0100; mask = 32'd0; status_clr = 3'b111;
    tick();
    status_clr = 0;
    check("R8", "no match on unmasked diff", {29'd0, status}, 32'd0);

    for (int i = 0; i < 32; i++) begin
      check("R3", "serial bit", {31'd0, pin_out}, {31'd0, word_b[i]});
      shift_en = 1; tick();
    end
    shift_en = 0;

    // Sweep: reload values x direction x chaining (R2..R10)
    for (int ri = 0; ri < 4; ri++) begin
      for (int d = 0; d < 2; d++) begin
        for (int c = 0; c < 2; c++) begin
          pos_reload = reloads[ri]; dir_out = d[0]; use_cascade = c[0];
          pattern = rnd(seed); mask = 32'hFFFF_FFF8;
          do_reset();
          for (int n = 0; n < 150; n++) begin
            r = rnd(seed);
            shift_en     = r[0] | r[1];
            pin_in       = r[2];
            cascade_in   = r[3];
            shadow_wr    = (r[7:4] == 4'd0) || (r[7:4] == 4'd1 && ri == 0);
            status_clr   = r[10:8] & {3{r[11]}};
            irq_en       = r[14:12];
            shadow_wdata = rnd(seed);
            tick();
          end
          shadow_wr = 0; status_clr = 0; shift_en = 0;
        end
      end
    end

    // Long alternating capture to reach the divider's top bit (R10)
    pos_reload = 8'd31; dir_out = 0; use_cascade = 0; mask = 32'hFFFF_FFFF;
    do_reset();
    for (int n = 0; n < 600; n++) begin
      shift_en = 1; pin_in = n[0];
      tick();
    end
    check("R10", "divider reached top bit", {31'd0, div128_out}, {31'd0, m_edges[6]});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule